// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mixed Pin Sensitivity

This block gathers interrupt requests from six external pins, five internal request lines and a per-source software set vector, and presents to the processor core the single winning request. The core sees a request flag, the winning source index and a vector address. The core answers with an acknowledge strobe and the index it took. The acknowledge drops any latched request of that source.

The eleven sources have a fixed priority in which the lower index wins. Power-down is index 0. It cannot be masked and it ignores the global enable. Every other source is gated by its own mask bit and by a global enable. Each external pin is active low and has its own sensitivity. Pins 0 to 2 select edge or level mode from a configuration vector. Pins 3 and 4 are always level-sensitive. Pin 5 is always edge-sensitive. Pins 3 to 5 also serve as general-purpose flag outputs, and a value driven on such a pin raises the pin's own interrupt exactly as an outside device would. Chip reset dominates everything: while it is held, nothing is presented.

Top module: `pic_top`

## Requirements
- R1: While `rst_n` is low, `req_o` is 0 and every latched request is cleared. A request that pulses during reset is not presented after release.
- R2: Source indices are: 0 power-down (`int_req[4]`), 1 pin 0, 2 pin 3, 3 pin 4, 4 serial transmit (`int_req[0]`), 5 serial receive (`int_req[1]`), 6 pin 5, 7 byte DMA (`int_req[2]`), 8 pin 1, 9 pin 2, 10 timer (`int_req[3]`). Among eligible sources, the lowest index is presented.
- R3: A source with index 1 to 10 is eligible only when `irq_mask[index]` is 1 and `glob_en` is 1. Otherwise it is not presented, but its latched state is kept.
- R4: Power-down (index 0) is presented whenever it is pending, whatever the values of `irq_mask` and `glob_en`.
- R5: Pin 5 is edge-sensitive. A falling edge latches a request that stays pending after the pin returns high, until that request is acknowledged.
- R6: Pins 3 and 4 are level-sensitive. Their sources are pending only while the synchronized pin is low, and nothing is latched.
- R7: For pins 0 to 2, `sens_edge[k]` = 1 selects falling-edge latching and 0 selects level sensitivity.
- R8: `ack` = 1 with `ack_idx` = i clears the latched request of source i. The cycle after the acknowledge edge already presents the next winner. A level source that is still asserted stays pending.
- R9: A high `soft_set[i]` for one cycle latches a request on source i. This request clears when source i is acknowledged.
- R10: For j = 0 to 2, while `flag_drive[j]` = 1, pin 3+j takes its value from `flag_val[j]` and the `ext_pin_n[3+j]` input is ignored.
- R11: `req_vec` = `VEC_BASE` + 4 × `req_idx`. The outputs are registered. An internal pulse is presented two clock edges after it is driven, and an external pin change is presented three edges after it is driven.
- R12: A high `int_req` bit for one cycle latches a request on the mapped source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 6 | External request pins, active low |
| flag_drive | input | 3 | Flag output enable for pins 3..5 |
| flag_val | input | 3 | Level driven onto pins 3..5 when enabled |
| sens_edge | input | 3 | Edge (1) or level (0) mode for pins 0..2 |
| int_req | input | 5 | Internal request pulses |
| soft_set | input | 11 | Software request set, one bit per source |
| irq_mask | input | 11 | Per-source enable (bit 0 unused) |
| glob_en | input | 1 | Global enable for maskable sources |
| ack | input | 1 | Core acknowledge strobe |
| ack_idx | input | 4 | Index being acknowledged |
| req_o | output | 1 | Request to the core |
| req_idx | output | 4 | Winning source index |
| req_vec | output | 14 | Vector address of the winner |

## Verification
The bench goes after the points where the two kinds of sensitivity differ. It checks that an edge request survives the pin going back high, and a design that failed to latch it would drop the request. It checks that an acknowledged level source is presented again at once, and a design that latched level pins would lose it. It checks that a masked request reappears when it is unmasked, and that power-down is granted with every mask and the global enable off. A design that put the mask on the latch, or gated power-down, would show the wrong index or no request at all. It checks a flag-driven pin that raises an interrupt while its outside input is ignored, and simultaneous requests whose winner and vector must follow the fixed order after each acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC   = 11;
  localparam int IDX_W  = 4;
  localparam int NEXT   = 6;
  localparam int NINT   = 5;
  localparam int NSEL   = 3;
  localparam int NFLAG  = 3;
  localparam int PIN_FLAG0 = 3;
  localparam int PIN_EDGE  = 5;

  // source index served by each external pin (pins 0..2 selectable, 3..4 level, 5 edge)
  localparam int EXT_SRC [NEXT] = '{1, 8, 9, 2, 3, 6};
  // source index served by each internal line (tx, rx, byte dma, timer, power-down)
  localparam int INT_SRC [NINT] = '{4, 5, 7, 10, 0};
endpackage

// File: rtl/pic_pin_sync.sv
module pic_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic active,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign active = ~sh_q[STAGES-1];
  assign fall   = sh_q[STAGES-1] & ~sh_q[STAGES-2];
endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;

  // a new event in the acknowledge cycle is kept, never lost
  always_comb begin
    pend_d = (pend_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int             N        = 11,
  parameter int             IDX_W    = 4,
  parameter int             VEC_W    = 14,
  parameter logic [VEC_W-1:0] VEC_BASE = 14'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     elig,
  output logic             req_o,
  output logic [IDX_W-1:0] req_idx,
  output logic [VEC_W-1:0] req_vec
);
  logic             req_d;
  logic [IDX_W-1:0] idx_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    req_d = 1'b0;
    idx_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        req_d = 1'b1;
        idx_d = IDX_W'(i);
      end
    end
    vec_d = VEC_BASE + (VEC_W'(idx_d) << 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      req_idx <= '0;
      req_vec <= '0;
    end else begin
      req_o   <= req_d;
      req_idx <= idx_d;
      req_vec <= req_d ? vec_d : '0;
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int               VEC_W       = 14,
  parameter logic [VEC_W-1:0] VEC_BASE    = 14'h0040,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin_n,
  input  logic [NFLAG-1:0] flag_drive,
  input  logic [NFLAG-1:0] flag_val,
  input  logic [NSEL-1:0]  sens_edge,
  input  logic [NINT-1:0]  int_req,
  input  logic [NSRC-1:0]  soft_set,
  input  logic [NSRC-1:0]  irq_mask,
  input  logic             glob_en,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             req_o,
  output logic [IDX_W-1:0] req_idx,
  output logic [VEC_W-1:0] req_vec
);
  logic [NEXT-1:0] pin_eff;
  logic [NEXT-1:0] pin_act;
  logic [NEXT-1:0] pin_fall;
  logic [NSRC-1:0] lvl_now;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] gate;
  logic [NSRC-1:0] elig;

  // pins 3..5 double as flag outputs; a driven flag replaces the outside level
  for (genvar p = 0; p < NEXT; p++) begin : g_pin
    if (p >= PIN_FLAG0) begin : g_flag
      assign pin_eff[p] = flag_drive[p-PIN_FLAG0] ? flag_val[p-PIN_FLAG0] : ext_pin_n[p];
    end else begin : g_plain
      assign pin_eff[p] = ext_pin_n[p];
    end
    pic_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (pin_eff[p]),
      .active (pin_act[p]),
      .fall   (pin_fall[p])
    );
  end

  always_comb begin
    lvl_now = '0;
    set_vec = soft_set;
    for (int p = 0; p < NSEL; p++) begin
      if (sens_edge[p]) set_vec[EXT_SRC[p]] = set_vec[EXT_SRC[p]] | pin_fall[p];
      else              lvl_now[EXT_SRC[p]] = pin_act[p];
    end
    for (int p = NSEL; p < PIN_EDGE; p++) begin
      lvl_now[EXT_SRC[p]] = pin_act[p];
    end
    set_vec[EXT_SRC[PIN_EDGE]] = set_vec[EXT_SRC[PIN_EDGE]] | pin_fall[PIN_EDGE];
    for (int i = 0; i < NINT; i++) begin
      set_vec[INT_SRC[i]] = set_vec[INT_SRC[i]] | int_req[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      clr_vec[i] = ack && (ack_idx == IDX_W'(i));
      gate[i]    = (i == 0) ? 1'b1 : (irq_mask[i] & glob_en);
    end
    live = (pend_q & ~clr_vec) | lvl_now;
    elig = live & gate;
  end

  pic_pend #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (set_vec),
    .clr    (clr_vec),
    .pend_q (pend_q)
  );

  pic_arb #(
    .N        (NSRC),
    .IDX_W    (IDX_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .req_o   (req_o),
    .req_idx (req_idx),
    .req_vec (req_vec)
  );
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int               VEC_W    = 14,
  parameter logic [VEC_W-1:0] VEC_BASE = 14'h0040
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glob_en,
  input logic [NSRC-1:0]  irq_mask,
  input logic             ack,
  input logic [IDX_W-1:0] ack_idx,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  pend_q,
  input logic             req_o,
  input logic [IDX_W-1:0] req_idx,
  input logic [VEC_W-1:0] req_vec
);
  // R1: nothing presented while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!req_o && pend_q == '0);
    end
  end

  // R2: winner index is a real source
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (req_idx < IDX_W'(NSRC)));

  // R3: a maskable winner was enabled in the arbitration cycle
  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && req_idx != '0) |-> ($past(glob_en) && ((($past(irq_mask)) >> req_idx) & NSRC'(1)) != '0));

  // R3: with the global enable low only power-down can be granted
  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !pend_q[0]) |=> !req_o);

  // R4: latched power-down always wins next cycle
  p_pwd_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !(ack && ack_idx == '0)) |=> (req_o && req_idx == '0));

  // R5: the fixed-edge request stays until acknowledged
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[6] && !(ack && ack_idx == IDX_W'(6))) |=> pend_q[6]);

  // R8: acknowledge drops the latch when no new event arrives with it
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx < IDX_W'(NSRC) && !set_vec[ack_idx]) |=> !pend_q[$past(ack_idx)]);

  // R11: vector low bits follow the base
  p_vec_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (req_vec[1:0] == VEC_BASE[1:0]));
endmodule

bind pic_top pic_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glob_en  (glob_en),
  .irq_mask (irq_mask),
  .ack      (ack),
  .ack_idx  (ack_idx),
  .set_vec  (set_vec),
  .pend_q   (pend_q),
  .req_o    (req_o),
  .req_idx  (req_idx),
  .req_vec  (req_vec)
);

// File: tb/pic_top_tb_top.sv
`timescale 1ns/1ps
module pic_top_tb_top;
  localparam logic [13:0] BASE = 14'h0040;

  logic        clk;
  logic        rst_n;
  logic [5:0]  ext_pin_n;
  logic [2:0]  flag_drive;
  logic [2:0]  flag_val;
  logic [2:0]  sens_edge;
  logic [4:0]  int_req;
  logic [10:0] soft_set;
  logic [10:0] irq_mask;
  logic        glob_en;
  logic        ack;
  logic [3:0]  ack_idx;
  logic        req_o;
  logic [3:0]  req_idx;
  logic [13:0] req_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pic_top #(.VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .flag_drive(flag_drive),
    .flag_val(flag_val), .sens_edge(sens_edge), .int_req(int_req),
    .soft_set(soft_set), .irq_mask(irq_mask), .glob_en(glob_en), .ack(ack),
    .ack_idx(ack_idx), .req_o(req_o), .req_idx(req_idx), .req_vec(req_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input bit exp_req, input int exp_idx);
    logic [13:0] exp_vec;
    checks++;
    exp_vec = BASE + 14'(exp_idx * 4);
    if (req_o !== exp_req) begin
      errors++;
      $display("FAIL %s req actual=%0b expected=%0b", tag, req_o, exp_req);
    end else if (exp_req && (req_idx !== 4'(exp_idx) || req_vec !== exp_vec)) begin
      errors++;
      $display("FAIL %s idx/vec actual=%0d/%h expected=%0d/%h", tag, req_idx, req_vec, exp_idx, exp_vec);
    end
  endtask

  task automatic pulse_int(input logic [4:0] m);
    int_req = m; step(1); int_req = '0; step(1);
  endtask

  task automatic do_ack(input int k);
    ack = 1'b1; ack_idx = 4'(k); step(1); ack = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(1);
    int_req = 5'b11111; step(1); int_req = '0; step(1);
    chk("R1 during reset", 1'b0, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 after release", 1'b0, 0);
  endtask

  task automatic t_internal_prio;
    pulse_int(5'b01100);            // byte dma (7) and timer (10)
    chk("R12 R2 R11 dma over timer", 1'b1, 7);
    do_ack(7);
    chk("R8 R2 timer next", 1'b1, 10);
    do_ack(10);
    chk("R8 idle after acks", 1'b0, 0);
    pulse_int(5'b00011);            // tx (4) and rx (5)
    chk("R2 tx over rx", 1'b1, 4);
    do_ack(4);
    chk("R2 rx next", 1'b1, 5);
    do_ack(5);
  endtask

  task automatic t_mask;
    irq_mask[7] = 1'b0;
    pulse_int(5'b00100);
    chk("R3 masked dma hidden", 1'b0, 0);
    irq_mask[7] = 1'b1; step(1);
    chk("R3 unmask shows kept request", 1'b1, 7);
    glob_en = 1'b0; step(1);
    chk("R3 global enable off", 1'b0, 0);
    glob_en = 1'b1; step(1);
    do_ack(7);
    chk("R3 cleared", 1'b0, 0);
  endtask

  task automatic t_pwd;
    glob_en = 1'b0; irq_mask = '0;
    pulse_int(5'b11000);            // power-down and timer
    chk("R4 power-down unmaskable", 1'b1, 0);
    do_ack(0);
    chk("R4 power-down acked", 1'b0, 0);
    glob_en = 1'b1; irq_mask = '1; step(1);
    chk("R4 timer after enable", 1'b1, 10);
    do_ack(10);
  endtask

  task automatic t_edge_fixed;
    ext_pin_n[5] = 1'b0; step(3);
    chk("R5 R11 edge pin latched", 1'b1, 6);
    ext_pin_n[5] = 1'b1; step(3);
    chk("R5 edge pin sticky after release", 1'b1, 6);
    do_ack(6);
    chk("R5 R8 edge pin acked", 1'b0, 0);
  endtask

  task automatic t_level_fixed;
    ext_pin_n[3] = 1'b0; step(3);
    chk("R6 level pin low", 1'b1, 2);
    do_ack(2);
    chk("R8 level stays after ack", 1'b1, 2);
    pulse_int(5'b00001);
    chk("R2 level pin over tx", 1'b1, 2);
    ext_pin_n[3] = 1'b1; step(3);
    chk("R6 level pin released", 1'b1, 4);
    do_ack(4);
    chk("R6 idle", 1'b0, 0);
  endtask

  task automatic t_prog;
    sens_edge = 3'b000;
    ext_pin_n[0] = 1'b0; step(3);
    chk("R7 pin0 level mode", 1'b1, 1);
    ext_pin_n[0] = 1'b1; step(3);
    chk("R7 pin0 level not latched", 1'b0, 0);
    sens_edge = 3'b011; step(1);
    ext_pin_n[0] = 1'b0; ext_pin_n[1] = 1'b0; step(1);
    ext_pin_n[0] = 1'b1; ext_pin_n[1] = 1'b1; step(3);
    chk("R7 pin0 edge latched", 1'b1, 1);
    do_ack(1);
    chk("R7 pin1 edge latched", 1'b1, 8);
    do_ack(8);
    chk("R7 edge cleared", 1'b0, 0);
    sens_edge = 3'b000;
  endtask

  task automatic t_soft;
    soft_set = 11'h020; step(1); soft_set = '0; step(1);
    chk("R9 soft request", 1'b1, 5);
    do_ack(5);
    chk("R9 soft self-clear", 1'b0, 0);
  endtask

  task automatic t_flag;
    flag_drive[1] = 1'b1; flag_val[1] = 1'b0; step(3);
    chk("R10 driven flag raises own irq", 1'b1, 3);
    flag_val[1] = 1'b1; ext_pin_n[4] = 1'b0; step(3);
    chk("R10 outside pin ignored while driven", 1'b0, 0);
    flag_drive[1] = 1'b0; step(3);
    chk("R10 outside pin after release", 1'b1, 3);
    ext_pin_n[4] = 1'b1; step(3);
    flag_drive[2] = 1'b1; flag_val[2] = 1'b0; step(1); flag_val[2] = 1'b1; step(3);
    chk("R10 R5 driven edge pin latched", 1'b1, 6);
    do_ack(6);
    flag_drive = '0;
    chk("R10 cleared", 1'b0, 0);
  endtask

  initial begin
    rst_n = 1'b0; ext_pin_n = '1; flag_drive = '0; flag_val = '1;
    sens_edge = '0; int_req = '0; soft_set = '0; irq_mask = '1;
    glob_en = 1'b1; ack = 1'b0; ack_idx = '0;
    step(2);
    t_reset();
    t_internal_prio();
    t_mask();
    t_pwd();
    t_edge_fixed();
    t_level_fixed();
    t_prog();
    t_soft();
    t_flag();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule